// File: doc/BRIEF.md
# MDIO Management Bus Master

This block carries out single register accesses to an external PHY over a two-wire serial management link. One wire is a clock (MDC) that the block drives. The other is a shared data line (MDIO), which the block drives through an output, an output enable and an input. A host starts a transfer with a one-cycle strobe. With the strobe it gives a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block holds `busy_o` high for the whole exchange. At the end it gives a one-cycle `done_o` pulse, which also loads the read result and the error flag.

Every frame opens with 32 preamble cycles of MDIO high. A 14-bit header follows. A read then releases the line for the turnaround and checks that the PHY pulls it low. If the PHY does, the read collects 16 data bits and finishes with two released clocks. If the PHY does not, the read clocks a 32-cycle flush and reports an error. A write drives the turnaround and its data, then releases the line for one final clock. The MDC half-period is set by `half_div_i`, counted in system clocks and captured when the transfer starts.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transfers, `mdc_o` is 1, `mdio_oe_o` is 0 and `busy_o` is 0.
- R2: Each transfer begins with 32 MDC cycles. During them MDIO is driven with the enable on and the value 1.
- R3: The next 14 MDC cycles drive a header, each bit placed while MDC is low. The header is the start code 0,1, then the opcode (1,0 for read, 0,1 for write), then the PHY address MSB first, then the register address MSB first.
- R4: Each MDC half-phase lasts `half_div_i` system clocks, with 0 treated as 1. The divider value is captured when the transfer starts.
- R5: On a read, the output enable is off during the first turnaround cycle. MDIO (after a two-flop synchronizer) is sampled at the end of that cycle's high half, and 0 means a PHY answered. The next 16 cycles capture data MSB first, each at the end of its high half.
- R6: A successful read adds two released MDC cycles after the data, for 65 MDC cycles in total. It completes with `err_o`=0 and `rdata_o` equal to the captured word.
- R7: If the turnaround sample is 1, 32 further MDC cycles follow with MDIO released, 79 in total. The transfer completes with `err_o`=1 and `rdata_o`=0.
- R8: A write drives turnaround bits 1,0 and then 16 data bits MSB first. It then releases MDIO for one extra MDC cycle, for 65 in total, and completes with `err_o`=0 and `rdata_o`=0.
- R9: `done_o` is a single-cycle pulse asserted as `busy_o` falls. `rdata_o` and `err_o` change only with it.
- R10: A start strobe while `busy_o` is 1 is ignored: it does not alter the running frame and does not start another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| read_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| half_div_i | input | 8 | MDC half-period in system clocks (0 acts as 1) |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result, loaded with done |
| err_o | output | 1 | No PHY answered the turnaround, loaded with done |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench models a PHY that watches MDC edges. Writes are run with data whose ones sit only at the top or only at the bottom bit, and with alternating data, so a reversed or shifted data order shows up. Reads are run with all-ones, all-zeros and mixed words, and PHY and register addresses run from 0 to 31, so bit order in both the header and the capture is pinned down. A read with the PHY absent tells the error and flush path apart from a normal read by its MDC cycle count and its outputs. Divider values 0, 1, 2, 3, 4 and 5 separate a correct half-phase length from an off-by-one, and a strobe pulsed in the middle of a transfer shows whether a busy master really ignores it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SEND,
    S_TA,
    S_RECV,
    S_FLUSH,
    S_TAIL
  } mdio_state_e;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  localparam int unsigned RD_TAIL_CYC = 2;
  localparam int unsigned WR_TAIL_CYC = 1;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/mdio_tick.sv
module mdio_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // divider is captured per transfer; 0 acts as 1
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     div_q <= DIV_W'(1);
    else if (load_i) div_q <= (div_i == '0) ? DIV_W'(1) : div_i;

  assign lim    = div_q - DIV_W'(1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= lim));

  p_div_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q != '0);

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PRE_CYC   = 32,
  parameter int unsigned FLUSH_CYC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              mdi_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);

  localparam int unsigned HDR_BITS   = 4 + 2 * ADDR_W;
  localparam int unsigned FRAME_BITS = HDR_BITS + 2 + DATA_W;
  localparam int unsigned CNT_W      = $clog2(PRE_CYC + FLUSH_CYC + FRAME_BITS + 1);

  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] FLUSH_LAST = CNT_W'(FLUSH_CYC - 1);
  localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] RTAIL_LAST = CNT_W'(RD_TAIL_CYC - 1);
  localparam logic [CNT_W-1:0] WTAIL_LAST = CNT_W'(WR_TAIL_CYC - 1);

  mdio_state_e           state_q;
  logic                  half_q;     // 0: low half of the MDC cycle, 1: high half
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic                  rd_q;
  logic [DATA_W-1:0]     rx_q;
  logic                  mdc_q, mdo_q, oe_q, done_q, err_q;
  logic [DATA_W-1:0]     rdata_q;

  logic [CNT_W-1:0] send_last, tail_last;
  logic             cyc_end;

  assign send_last = rd_q ? HDR_LAST : FRAME_LAST;
  assign tail_last = rd_q ? RTAIL_LAST : WTAIL_LAST;
  assign cyc_end   = tick_i && half_q;
  assign load_o    = (state_q == S_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      rx_q    <= '0;
      mdc_q   <= 1'b1;
      mdo_q   <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start_i) begin
          state_q <= S_PRE;
          half_q  <= 1'b0;
          cnt_q   <= '0;
          mdc_q   <= 1'b0;
          mdo_q   <= 1'b1;
          oe_q    <= 1'b1;
          rd_q    <= read_i;
          sh_q    <= {SOF_CODE, (read_i ? OP_READ : OP_WRITE), phy_i, reg_i, TA_WRITE, wdata_i};
        end
      end else if (tick_i && !half_q) begin
        half_q <= 1'b1;
        mdc_q  <= 1'b1;
      end else if (cyc_end) begin
        // close the current MDC cycle, open the next low half
        half_q <= 1'b0;
        mdc_q  <= 1'b0;
        cnt_q  <= cnt_q + CNT_W'(1);
        unique case (state_q)
          S_PRE: begin
            if (cnt_q == PRE_LAST) begin
              state_q <= S_SEND;
              cnt_q   <= '0;
              mdo_q   <= sh_q[FRAME_BITS-1];
              sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
          end
          S_SEND: begin
            if (cnt_q == send_last) begin
              cnt_q   <= '0;
              oe_q    <= 1'b0;
              mdo_q   <= 1'b1;
              state_q <= rd_q ? S_TA : S_TAIL;
            end else begin
              mdo_q <= sh_q[FRAME_BITS-1];
              sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
          end
          S_TA: begin
            cnt_q   <= '0;
            state_q <= mdi_i ? S_FLUSH : S_RECV;
          end
          S_RECV: begin
            rx_q <= {rx_q[DATA_W-2:0], mdi_i};
            if (cnt_q == DATA_LAST) begin
              cnt_q   <= '0;
              state_q <= S_TAIL;
            end
          end
          S_FLUSH: begin
            if (cnt_q == FLUSH_LAST) begin
              state_q <= S_IDLE;
              mdc_q   <= 1'b1;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end
          end
          S_TAIL: begin
            if (cnt_q == tail_last) begin
              state_q <= S_IDLE;
              mdc_q   <= 1'b1;
              done_q  <= 1'b1;
              err_q   <= 1'b0;
              rdata_q <= rd_q ? rx_q : '0;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign mdc_o   = mdc_q;
  assign mdo_o   = mdo_q;
  assign oe_o    = oe_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> (mdc_q && !oe_q));

  p_preamble_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PRE) |-> (oe_q && mdo_q));

  p_oe_moves_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(oe_q) || $fell(oe_q)) |-> !mdc_q);

  p_data_moves_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !$stable(mdo_q)) |-> !mdc_q);

  p_mdc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(mdc_q));

  p_released_after_ta_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TA || state_q == S_RECV || state_q == S_FLUSH) |-> !oe_q);

  p_err_no_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && err_q) |-> (rdata_q == '0));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_result_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_q |-> ($stable(rdata_q) && $stable(err_q)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_CYC     = 32,
  parameter int unsigned FLUSH_CYC   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              read_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  half_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);

  logic mdi_sync;
  logic tick;
  logic load;

  mdio_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mdio_i),
    .q_o    (mdi_sync)
  );

  mdio_tick #(.DIV_W(DIV_W)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .load_i (load),
    .div_i  (half_div_i),
    .tick_o (tick)
  );

  mdio_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PRE_CYC   (PRE_CYC),
    .FLUSH_CYC (FLUSH_CYC)
  ) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .read_i  (read_i),
    .phy_i   (phy_addr_i),
    .reg_i   (reg_addr_i),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .mdi_i   (mdi_sync),
    .busy_o  (busy_o),
    .load_o  (load),
    .mdc_o   (mdc_o),
    .mdo_o   (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done_o),
    .rdata_o (rdata_o),
    .err_o   (err_o)
  );

  p_done_not_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_ends_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int DIV_W = 8;
  localparam int CLK_HALF = 10; // 20 units per cycle: 50 MHz at 1 ns units

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        read_sel = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wdata = '0;
  logic [DIV_W-1:0] half_div = DIV_W'(3);
  logic        busy, done, err, mdc, mdio_out, mdio_oe;
  logic [15:0] rdata;
  logic        phy_drv = 1'b1;
  logic        mdio_in;

  always #CLK_HALF clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_out : phy_drv;

  mdio_master i_mdio_master (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .read_i     (read_sel),
    .phy_addr_i (phy_addr),
    .reg_addr_i (reg_addr),
    .wdata_i    (wdata),
    .half_div_i (half_div),
    .busy_o     (busy),
    .done_o     (done),
    .rdata_o    (rdata),
    .err_o      (err),
    .mdc_o      (mdc),
    .mdio_o     (mdio_out),
    .mdio_oe_o  (mdio_oe),
    .mdio_i     (mdio_in)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- PHY model and line recorder ----------------
  int  n_rise = 0, n_fall = 0;
  int  rise_base = 0, fall_base = 0;
  logic rec_oe  [0:127];
  logic rec_val [0:127];
  longint t_rise0 = 0, t_fall1 = 0;
  bit          phy_present = 1'b1;
  logic [15:0] phy_data = '0;

  always @(posedge mdc) begin
    automatic int rel = n_rise - rise_base;
    if (rel >= 0 && rel < 128) begin
      rec_oe[rel]  = mdio_oe;
      rec_val[rel] = mdio_out;
    end
    if (rel == 0) t_rise0 = $time;
    n_rise++;
  end

  always @(negedge mdc) begin
    automatic int rel = n_fall - fall_base;
    if (rel == 1) t_fall1 = $time;
    if (rel == 46)
      phy_drv = !phy_present;
    else if (rel >= 47 && rel < 63 && phy_present)
      phy_drv = phy_data[62-rel];
    else
      phy_drv = 1'b1;
    n_fall++;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          rd;
    logic [4:0]  pa;
    logic [4:0]  ra;
    logic [15:0] wd;
    bit          present;
    logic [15:0] pd;
    int          div;
  } txn_t;

  txn_t exp_q[$];
  bit   done_d = 1'b0;

  always @(negedge clk) begin
    if (done_d) chk("R9", "done lasts one cycle", 32'(done), 32'd0);
    done_d = done;
    if (done) begin
      if (exp_q.size() == 0) begin
        chk("R10", "unexpected completion", 32'd1, 32'd0);
      end else begin
        automatic txn_t t = exp_q.pop_front();
        automatic int cyc = n_rise - rise_base;
        automatic int exp_cyc = t.rd ? (t.present ? 65 : 79) : 65;
        automatic bit ok = 1'b1;
        automatic logic [13:0] hdr = '0;
        automatic logic [13:0] hdr_exp = {2'b01, (t.rd ? 2'b10 : 2'b01), t.pa, t.ra};
        automatic int exp_half = (t.div == 0) ? 1 : t.div;

        chk("R9", "busy low at done", 32'(busy), 32'd0);
        chk("R4", "high half length", 32'((t_fall1 - t_rise0) / (2 * CLK_HALF)), 32'(exp_half));

        for (int i = 0; i < 32; i++) if (!(rec_oe[i] === 1'b1 && rec_val[i] === 1'b1)) ok = 1'b0;
        chk("R2", "preamble driven high", 32'(ok), 32'd1);

        ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
          hdr = {hdr[12:0], rec_val[32+i]};
          if (rec_oe[32+i] !== 1'b1) ok = 1'b0;
        end
        chk("R3", "header bits", 32'(hdr), 32'(hdr_exp));
        chk("R3", "header driven", 32'(ok), 32'd1);

        if (t.rd && t.present) begin
          chk("R6", "cycle count", 32'(cyc), 32'(exp_cyc));
          chk("R5", "turnaround released", 32'(rec_oe[46]), 32'd0);
          ok = 1'b1;
          for (int i = 46; i < 65; i++) if (rec_oe[i] !== 1'b0) ok = 1'b0;
          chk("R6", "released through trailer", 32'(ok), 32'd1);
          chk("R5", "read data", 32'(rdata), 32'(t.pd));
          chk("R6", "no error", 32'(err), 32'd0);
        end else if (t.rd) begin
          chk("R7", "cycle count", 32'(cyc), 32'(exp_cyc));
          ok = 1'b1;
          for (int i = 46; i < 79; i++) if (rec_oe[i] !== 1'b0) ok = 1'b0;
          chk("R7", "released through flush", 32'(ok), 32'd1);
          chk("R7", "error flag", 32'(err), 32'd1);
          chk("R7", "no data", 32'(rdata), 32'd0);
        end else begin
          automatic logic [17:0] wr = '0;
          chk("R8", "cycle count", 32'(cyc), 32'(exp_cyc));
          ok = 1'b1;
          for (int i = 0; i < 18; i++) begin
            wr = {wr[16:0], rec_val[46+i]};
            if (rec_oe[46+i] !== 1'b1) ok = 1'b0;
          end
          chk("R8", "turnaround and data", 32'(wr), 32'({2'b10, t.wd}));
          chk("R8", "data driven", 32'(ok), 32'd1);
          chk("R8", "released last cycle", 32'(rec_oe[64]), 32'd0);
          chk("R8", "no error", 32'(err), 32'd0);
          chk("R8", "rdata cleared", 32'(rdata), 32'd0);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit present, input logic [15:0] pd,
                         input int div, input bit poke);
    txn_t t;
    logic [15:0] held;
    logic        held_err;
    t.rd = rd; t.pa = pa; t.ra = ra; t.wd = wd; t.present = present; t.pd = pd; t.div = div;
    @(negedge clk);
    phy_present = present;
    phy_data    = pd;
    rise_base   = n_rise;
    fall_base   = n_fall;
    read_sel    = rd;
    phy_addr    = pa;
    reg_addr    = ra;
    wdata       = wd;
    half_div    = DIV_W'(div);
    held        = rdata;
    held_err    = err;
    exp_q.push_back(t);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (100) @(negedge clk);
      read_sel = !rd; phy_addr = ~pa; reg_addr = ~ra; wdata = ~wd;
      half_div = DIV_W'(div + 2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9", "rdata held mid-transfer", 32'(rdata), 32'(held));
      chk("R9", "err held mid-transfer", 32'(err), 32'(held_err));
    end
    @(posedge done);
    repeat (6) @(negedge clk);
    chk("R10", "no restart after done", 32'(busy), 32'd0);
    chk("R1", "mdc idles high", 32'(mdc), 32'd1);
    chk("R1", "mdio released when idle", 32'(mdio_oe), 32'd0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset mdc", 32'(mdc), 32'd1);
    chk("R1", "reset oe", 32'(mdio_oe), 32'd0);
    chk("R1", "reset busy", 32'(busy), 32'd0);
    chk("R9", "reset done", 32'(done), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_txn(1'b0, 5'h01, 5'h00, 16'hA55A, 1'b1, 16'h0000, 3, 1'b0); // R8
    run_txn(1'b1, 5'h1F, 5'h02, 16'h0000, 1'b1, 16'h1234, 2, 1'b0); // R5
    run_txn(1'b1, 5'h10, 5'h1F, 16'h0000, 1'b0, 16'h0000, 3, 1'b0); // R7
    run_txn(1'b1, 5'h00, 5'h15, 16'h0000, 1'b1, 16'hFFFF, 5, 1'b0); // R6
    run_txn(1'b0, 5'h0A, 5'h11, 16'h0001, 1'b1, 16'h0000, 1, 1'b1); // R4 min, R10
    run_txn(1'b0, 5'h15, 5'h0A, 16'h8000, 1'b1, 16'h0000, 0, 1'b0); // R4 zero
    run_txn(1'b1, 5'h03, 5'h1C, 16'h0000, 1'b1, 16'h8001, 4, 1'b0); // R5
    run_txn(1'b1, 5'h07, 5'h04, 16'h0000, 1'b1, 16'h0000, 3, 1'b1); // R10 read

    repeat (20) @(negedge clk);
    chk("R10", "queue drained", 32'(exp_q.size()), 32'd0);
    summary();
    $finish;
  end

endmodule